// File: doc/BRIEF.md
# Comma-Detecting Byte Aligner

This block sits behind a clock-and-data recovery stage and receives one recovered line bit on every clock. It collects the bits into 10-bit characters and looks for the 8b/10b comma, a seven-bit run that in either polarity marks a character edge. When it finds a comma it can move its character boundary so that the comma lands exactly in one output word. After that, every following word is a complete, correctly framed character.

An enable input chooses between two policies. With the enable high, the aligner follows every comma it sees, wherever it falls. With the enable low, the aligner locks once. If it has never been aligned, the first comma it sees sets the boundary. If it is already aligned, a comma that falls off the boundary is ignored. A two-state machine keeps this history. HUNT means no alignment has been achieved yet. LOCKED means it has. The ACQUIRE transition goes from HUNT to LOCKED on the first comma that is emitted on a boundary. HOLD keeps the machine in LOCKED. Only reset returns the machine to HUNT.

A word is output one clock after its last bit arrives. A strobe marks each word, and a second pulse marks words that hold a boundary-aligned comma.

Top module: `comma_byte_aligner`

## Requirements
- R1: While reset is high and on the first sample after it, rx_word_valid and comma_seen are 0. After reset, the first word strobe comes one clock after the tenth bit.
- R2: rx_word bit 0 holds the earliest received bit of the word, and bit 9 holds the latest.
- R3: When no realignment happens, rx_word_valid pulses once every 10 clocks, measured from the current boundary.
- R4: A comma is a word whose bits [6:0] are 7'b1111100 (the received order 0,0,1,1,1,1,1) or 7'b0000011 (its complement). comma_seen pulses together with rx_word_valid for every emitted word that holds a comma, whatever the level of align_en.
- R5: With align_en at 1, a comma that lies off the boundary moves the boundary. The comma word is emitted one clock after its last bit, with comma_seen set. The partial word before it is never emitted, and the next strobe comes 10 clocks later.
- R6: With align_en at 0 in HUNT, only the first comma is aligned. Later off-boundary commas do not move the boundary and give no comma_seen.
- R7: With align_en at 0 in LOCKED, an off-boundary comma does not move the boundary, and comma_seen stays 0 for it.
- R8: Reset clears the alignment history, so after reset the first comma is aligned again even with align_en at 0.
- R9: A stream that contains no comma never raises comma_seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial bit, one per clock |
| align_en | input | 1 | 1 = realign on every comma, 0 = lock once |
| rx_word | output | 10 | Aligned character, bit 0 received first |
| rx_word_valid | output | 1 | One-clock strobe for each emitted word |
| comma_seen | output | 1 | One-clock pulse for an emitted word holding a comma |

## Verification
The hardest case to reach from the ports is an off-boundary comma that arrives in LOCKED with align_en low. Two things have to be set up first. The history flag must already be set, and the stream must be offset from the boundary by a known amount. The stimulus table first locks the aligner with align_en low, then enables it and realigns at a chosen offset. After that it lowers align_en and sends a comma a computed number of bits off the boundary. Every row then confirms by a later on-boundary comma that the boundary did not move.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    // Alignment history: HUNT until a comma is emitted on a boundary.
    typedef enum logic [0:0] {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_t;

    localparam int unsigned DEF_WORD_W  = 10;
    localparam int unsigned DEF_COMMA_W = 7;
    // Bit i is the i-th received bit: received order 0,0,1,1,1,1,1.
    localparam logic [DEF_COMMA_W-1:0] DEF_COMMA = 7'b1111100;

endpackage

// File: rtl/rx_shift_window.sv
module rx_shift_window #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    output logic [WORD_W-1:0] window
);

    // Newest bit enters at the top; window[0] is the oldest of the last WORD_W.
    always_ff @(posedge clk) begin
        if (rst) begin
            window <= '0;
        end else begin
            window <= {rx_bit, window[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/comma_matcher.sv
module comma_matcher #(
    parameter int unsigned             COMMA_W   = 7,
    parameter logic [COMMA_W-1:0]      COMMA_PAT = 7'b1111100,
    parameter bit                      MATCH_INV = 1'b1
) (
    input  logic [COMMA_W-1:0] head,
    output logic               hit
);

    logic pos_hit;
    assign pos_hit = (head == COMMA_PAT);

    generate
        if (MATCH_INV) begin : g_both_pol
            logic neg_hit;
            assign neg_hit = (head == ~COMMA_PAT);
            assign hit     = pos_hit | neg_hit;
        end else begin : g_one_pol
            assign hit = pos_hit;
        end
    endgenerate

endmodule

// File: rtl/boundary_counter.sv
module boundary_counter #(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic at_bnd
);

    logic [CNT_W-1:0] cnt;

    // cnt = number of bits of the current word held in the window.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(1);
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign at_bnd = (cnt == CNT_W'(WORD_W));

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W)) else $error("bit counter past word size"); // R3

    AST_BND_SPACED: assert property (@(posedge clk) disable iff (rst)
        at_bnd |=> !at_bnd) else $error("boundary on consecutive clocks"); // R3

endmodule

// File: rtl/comma_byte_aligner.sv
module comma_byte_aligner
    import aligner_pkg::*;
#(
    parameter int unsigned          WORD_W    = DEF_WORD_W,
    parameter int unsigned          COMMA_W   = DEF_COMMA_W,
    parameter logic [COMMA_W-1:0]   COMMA_PAT = DEF_COMMA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              align_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_valid,
    output logic              comma_seen
);

    align_state_t     state, state_nxt;
    logic [WORD_W-1:0] window;
    logic             hit;
    logic             at_bnd;
    logic             realign_ok;
    logic             take_word;
    logic             acquire;

    rx_shift_window #(.WORD_W(WORD_W)) u_window (
        .clk    (clk),
        .rst    (rst),
        .rx_bit (rx_bit),
        .window (window)
    );

    comma_matcher #(
        .COMMA_W   (COMMA_W),
        .COMMA_PAT (COMMA_PAT),
        .MATCH_INV (1'b1)
    ) u_match (
        .head (window[COMMA_W-1:0]),
        .hit  (hit)
    );

    boundary_counter #(.WORD_W(WORD_W)) u_bnd (
        .clk     (clk),
        .rst     (rst),
        .restart (take_word),
        .at_bnd  (at_bnd)
    );

    // Realignment allowed when enabled, or once while still hunting.
    assign realign_ok = align_en || (state == ST_HUNT);
    assign take_word  = at_bnd || (hit && realign_ok);
    assign acquire    = hit && take_word;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT:   state_nxt = acquire ? ST_LOCKED : ST_HUNT; // ACQUIRE
            ST_LOCKED: state_nxt = ST_LOCKED;                    // HOLD
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word       <= '0;
            rx_word_valid <= 1'b0;
            comma_seen    <= 1'b0;
        end else begin
            rx_word_valid <= take_word;
            comma_seen    <= acquire;
            if (take_word) begin
                rx_word <= window;
            end
        end
    end

    AST_SEEN_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> rx_word_valid) else $error("comma pulse without word"); // R4

    AST_SEEN_IS_COMMA: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> (rx_word[COMMA_W-1:0] == COMMA_PAT ||
                        rx_word[COMMA_W-1:0] == ~COMMA_PAT))
        else $error("comma pulse on non-comma word"); // R4

    AST_EN_REALIGNS: assert property (@(posedge clk) disable iff (rst)
        (align_en && hit) |=> (rx_word_valid && comma_seen))
        else $error("enabled comma not aligned"); // R5

    AST_LOCKED_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED && !align_en && hit && !at_bnd) |=> !rx_word_valid)
        else $error("locked aligner moved"); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED) |=> (state == ST_LOCKED))
        else $error("history flag cleared without reset"); // R8

endmodule

// File: tb/tb_comma_byte_aligner.sv
module tb_comma_byte_aligner;

    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] K_POS = 10'b0101111100;
    localparam logic [9:0] K_NEG = 10'b1010000011;
    // Row: {align_en, inverted, expect_seen, 1'b0, trail[3:0]}
    localparam int NROWS = 8;
    localparam logic [7:0] ROWS [NROWS] = '{
        8'b0010_0100, // HUNT, en0, off boundary -> first comma aligned (R6)
        8'b0000_0110, // LOCKED, en0, offset 4 -> ignored (R6)
        8'b0010_0011, // en0, on boundary -> seen (R4)
        8'b1010_1010, // en1, offset 3 -> realign (R5)
        8'b1010_0101, // en1, on boundary -> seen (R4)
        8'b0000_0111, // en0, offset 5 -> ignored (R7)
        8'b1110_1010, // en1, inverted, offset 2 -> realign (R5)
        8'b0110_0001  // en0, inverted, on boundary -> seen (R4)
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] rx_word;
    logic       rx_word_valid;
    logic       comma_seen;

    int checks = 0;
    int errors = 0;
    int bit_idx = 0;
    int seen_cnt = 0;
    int bad_word = 0;
    int vcnt = 0;
    int vat [8];
    bit done = 1'b0;

    comma_byte_aligner dut (
        .clk           (clk),
        .rst           (rst),
        .rx_bit        (rx_bit),
        .align_en      (align_en),
        .rx_word       (rx_word),
        .rx_word_valid (rx_word_valid),
        .comma_seen    (comma_seen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        seen_cnt = 0;
        bad_word = 0;
        vcnt = 0;
        bit_idx = 0;
    endtask

    // Drive at negedge, pass one posedge, sample at next negedge.
    task automatic send_bit(input logic b);
        rx_bit = b;
        @(posedge clk);
        @(negedge clk);
        bit_idx++;
        if (rx_word_valid && vcnt < 8) begin
            vat[vcnt] = bit_idx;
        end
        if (rx_word_valid) vcnt++;
        if (comma_seen) begin
            seen_cnt++;
            if (rx_word != K_POS && rx_word != K_NEG) bad_word++;
        end
    endtask

    task automatic send_fill(input int n);
        for (int j = 0; j < n; j++) send_bit(j[0]);
    endtask

    task automatic send_char(input logic [9:0] ch);
        for (int i = 0; i < 10; i++) send_bit(ch[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_bit = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(rx_word_valid == 1'b0, "R1 valid in reset", rx_word_valid, 0);
        check(comma_seen == 1'b0, "R1 seen in reset", comma_seen, 0);
        rst = 1'b0;
        clear_stats();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Stimulus table walk
        align_en = 1'b0;
        do_reset();
        send_fill(3);
        for (int r = 0; r < NROWS; r++) begin
            align_en = ROWS[r][7];
            seen_cnt = 0;
            bad_word = 0;
            send_char(ROWS[r][6] ? K_NEG : K_POS);
            send_fill(int'(ROWS[r][3:0]));
            check(seen_cnt == int'(ROWS[r][5]), $sformatf("R5/R6/R7 row %0d seen count", r),
                  seen_cnt, int'(ROWS[r][5]));
            check(bad_word == 0, $sformatf("R4 row %0d comma word", r), bad_word, 0);
        end

        // R8: reset clears history, lock-once applies again
        align_en = 1'b0;
        do_reset();
        send_fill(6);
        send_char(K_POS);
        send_fill(2);
        check(seen_cnt == 1, "R8 first comma after reset", seen_cnt, 1);
        check(bad_word == 0, "R8 comma word", bad_word, 0);

        // R1/R2/R3/R9: cadence from reset, bit order, no false comma
        align_en = 1'b1;
        do_reset();
        begin
            logic [9:0] w0;
            w0 = 10'b0000100101;
            for (int i = 0; i < 10; i++) send_bit(w0[i]);
            send_bit(1'b0);
            check(rx_word_valid == 1'b1, "R1 first strobe at bit 11", rx_word_valid, 1);
            check(rx_word == w0, "R2 bit order", int'(rx_word), int'(w0));
            send_fill(20);
            check(vcnt == 3, "R3 strobe count", vcnt, 3);
            check(vat[1] == 21 && vat[2] == 31, "R3 strobe spacing", vat[2], 31);
            check(seen_cnt == 0, "R9 no comma in data", seen_cnt, 0);
        end

        // R5: realign timing, partial word dropped
        align_en = 1'b1;
        do_reset();
        send_fill(4);
        send_char(K_POS);
        send_fill(12);
        check(vat[0] == 11, "R5 strobe before comma", vat[0], 11);
        check(vat[1] == 15, "R5 comma word one clock after last bit", vat[1], 15);
        check(vat[2] == 25, "R5 next strobe ten clocks later", vat[2], 25);
        check(seen_cnt == 1, "R5 comma seen once", seen_cnt, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule